// File: doc/BRIEF.md
# Inter-Thread FIFO Storage Cell

This block is one storage cell that moves 64-bit words from a producing thread to a consuming thread. It holds an eight-entry circular buffer with a head index and an occupancy count. It also keeps three tag flags: empty (E), full (F) and a software-owned trigger bit (T). Every access arrives on one request port. A two-bit view code picks how the access treats the cell:

- **bypass view:** peeks at or patches entries.
- **control view:** reads or writes the packed tag word.
- **empty/full views:** push and pop, in a blocking form and a non-blocking (try) form.

A request completes in the cycle in which `req_ready` is high alongside `req_valid`. Read data is valid on `rsp_rdata` in that same cycle, and the state update takes effect at the following clock edge.

A blocking read against a set E flag cannot complete, and neither can a blocking write against a set F flag. Such an access holds `req_ready` low. A small state machine parks the stalled access kind and shows it on `park_rd` or `park_wr`.

The machine has three states:

- **ST_IDLE:** moves to ST_WAIT_RD when a blocking read is stuck, or to ST_WAIT_WR when a blocking write is stuck.
- **ST_WAIT_RD:** returns to ST_IDLE on the edge that completes a push.
- **ST_WAIT_WR:** returns to ST_IDLE on the edge that completes a pop.

After the release, the waiting requester retries on the next cycle. The port may serve other accesses while an access is parked.

Top module: `itc_fifo_cell`

## Requirements
- R1: After reset the cell holds zero in every entry, the occupancy count is 0, E=1, F=0, T=0 and the mode flag is 1. A control-view read then returns 0x0000_0000_3002_0001 and a bypass read returns 0.
- R2: A control-view read returns a packed word with these fields, all other bits zero:
  - bits [31:28]: log2 of the depth, which is 3.
  - bits [21:18]: the occupancy count.
  - bit 17: the FIFO-mode flag, always 1.
  - bit 16: T.
  - bit 1: F.
  - bit 0: E.
- R3: A completed empty/full-view write with occupancy below 8 does three things:
  - It stores the data at (head + occupancy) mod 8.
  - It increments the occupancy.
  - It clears E, and sets F when the occupancy becomes 8.
- R4: A completed empty/full-view read with nonzero occupancy does four things:
  - It returns the head entry.
  - It advances the head mod 8.
  - It decrements the occupancy.
  - It clears F, and sets E when the occupancy becomes 0.
- R5: A blocking read (view 2, write flag 0) while E=1 keeps `req_ready` low and sets `park_rd` from the next cycle. The first completed push clears `park_rd` on its edge, and the read then completes on retry.
- R6: A blocking write (view 2, write flag 1) while F=1 keeps `req_ready` low and sets `park_wr` from the next cycle. The first completed pop clears `park_wr` on its edge, and the write then completes on retry.
- R7: Non-blocking accesses use view 3.
  - A non-blocking read at occupancy 0 completes, returns 0 and changes nothing.
  - A non-blocking write at occupancy 8 completes and is dropped.
- R8: A bypass read (view 0, write flag 0) returns the head entry without changing the head or the occupancy.
- R9: A bypass write (view 0, write flag 1) with nonzero occupancy replaces the entry at (head + occupancy − 1) mod 8. With occupancy 0 it changes nothing.
- R10: A control-view write (view 1, write flag 1) does two things:
  - It loads T, F and E from write-data bits 16, 1 and 0 and leaves all else unchanged.
  - When bit 0 is 1 it also sets the occupancy to 0.
- R11: Every request other than a stuck blocking access has `req_ready` high in the cycle it is presented. `req_ready` is low whenever `req_valid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_view | input | 2 | Access view: 0 bypass, 1 control, 2 blocking empty/full, 3 try empty/full |
| req_write | input | 1 | 1 for write, 0 for read |
| req_wdata | input | 64 | Write data |
| req_ready | output | 1 | Request completes this cycle |
| rsp_rdata | output | 64 | Read data of a completing read, else zero |
| park_rd | output | 1 | A blocking read is parked waiting for a push |
| park_wr | output | 1 | A blocking write is parked waiting for a pop |

## Verification
The hardest situation to reach is a parked blocking access that is released by an access of the opposite kind arriving on the same port. The stimulus first presents the stuck blocking request for two cycles, so that the park flag is seen high. It then swaps in a push or pop through a different view and finally retries the original request. A control write sets F on an empty cell, so that a blocking write stalls with no data present. That stall is later released only after a try-push and a blocking pop.

// File: rtl/itc_cell_pkg.sv
package itc_cell_pkg;

    typedef enum logic [1:0] {
        VIEW_BYPASS   = 2'd0,
        VIEW_CTRL     = 2'd1,
        VIEW_EF_BLOCK = 2'd2,
        VIEW_EF_TRY   = 2'd3
    } view_e;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_WAIT_RD = 2'd1,
        ST_WAIT_WR = 2'd2
    } park_state_e;

    localparam int TAG_DEPTH_LSB = 28;
    localparam int TAG_OCC_LSB   = 18;
    localparam int TAG_MODE_BIT  = 17;
    localparam int TAG_T_BIT     = 16;
    localparam int TAG_F_BIT     = 1;
    localparam int TAG_E_BIT     = 0;

endpackage

// File: rtl/itc_cell_store.sv
module itc_cell_store #(
    parameter int DEPTH = 8,
    parameter int WIDTH = 64,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_idx,
    input  logic [WIDTH-1:0] wr_data,
    input  logic [AW-1:0]    rd_idx,
    output logic [WIDTH-1:0] rd_data
);

    logic [WIDTH-1:0] slot_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot_q[g] <= '0;
            end else if (wr_en && wr_idx == AW'(g)) begin
                slot_q[g] <= wr_data;
            end
        end
    end

    assign rd_data = slot_q[rd_idx];

endmodule

// File: rtl/itc_cell_tags.sv
module itc_cell_tags #(
    parameter int DEPTH = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pop,
    input  logic          push,
    input  logic          ctl_wr,
    input  logic          ctl_t,
    input  logic          ctl_e,
    input  logic          ctl_f,
    output logic [AW-1:0] head,
    output logic [CW-1:0] count,
    output logic          tag_e,
    output logic          tag_f,
    output logic          tag_t
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head  <= '0;
            count <= '0;
            tag_e <= 1'b1;
            tag_f <= 1'b0;
            tag_t <= 1'b0;
        end else if (pop) begin
            head  <= head + AW'(1);
            count <= count - CW'(1);
            tag_f <= 1'b0;
            tag_e <= (count == CW'(1));
        end else if (push) begin
            count <= count + CW'(1);
            tag_e <= 1'b0;
            tag_f <= (count == CW'(DEPTH - 1));
        end else if (ctl_wr) begin
            tag_t <= ctl_t;
            tag_e <= ctl_e;
            tag_f <= ctl_f;
            if (ctl_e) begin
                count <= '0;
            end
        end
    end

    // R3
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));

    // R3
    push_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push |=> count == $past(count) + CW'(1) && !tag_e);

    // R4
    pop_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop |=> count == $past(count) - CW'(1) && !tag_f);

    // R10
    ctl_e_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && ctl_e && !pop && !push) |=> count == '0 && tag_e);

endmodule

// File: rtl/itc_cell_park_fsm.sv
module itc_cell_park_fsm
    import itc_cell_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic stuck_rd,
    input  logic stuck_wr,
    input  logic pop,
    input  logic push,
    output logic park_rd,
    output logic park_wr
);

    park_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (stuck_rd) begin
                    state_d = ST_WAIT_RD;
                end else if (stuck_wr) begin
                    state_d = ST_WAIT_WR;
                end
            end
            ST_WAIT_RD: if (push) state_d = ST_IDLE;
            ST_WAIT_WR: if (pop)  state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        park_rd = 1'b0;
        park_wr = 1'b0;
        unique case (state_q)
            ST_WAIT_RD: park_rd = 1'b1;
            ST_WAIT_WR: park_wr = 1'b1;
            default: ;
        endcase
    end

    // R5
    park_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({park_rd, park_wr}));

    // R5
    release_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (park_rd && push) |=> !park_rd);

    // R6
    release_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (park_wr && pop) |=> !park_wr);

endmodule

// File: rtl/itc_fifo_cell.sv
module itc_fifo_cell
    import itc_cell_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int WIDTH = 64,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [1:0]       req_view,
    input  logic             req_write,
    input  logic [WIDTH-1:0] req_wdata,
    output logic             req_ready,
    output logic [WIDTH-1:0] rsp_rdata,
    output logic             park_rd,
    output logic             park_wr
);

    view_e            view;
    logic [AW-1:0]    head;
    logic [CW-1:0]    count;
    logic             tag_e, tag_f, tag_t;
    logic             is_ef, stuck_rd, stuck_wr, fire;
    logic             not_empty, not_full;
    logic             pop, push, byp_wr, ctl_wr;
    logic [AW-1:0]    tail_idx, last_idx;
    logic [WIDTH-1:0] head_data, ctl_word;

    assign view      = view_e'(req_view);
    assign is_ef     = (view == VIEW_EF_BLOCK) || (view == VIEW_EF_TRY);
    assign stuck_rd  = req_valid && view == VIEW_EF_BLOCK && !req_write && tag_e;
    assign stuck_wr  = req_valid && view == VIEW_EF_BLOCK &&  req_write && tag_f;
    assign req_ready = req_valid && !stuck_rd && !stuck_wr;
    assign fire      = req_ready;

    assign not_empty = count != '0;
    assign not_full  = count != CW'(DEPTH);
    assign pop       = fire && is_ef && !req_write && not_empty;
    assign push      = fire && is_ef &&  req_write && not_full;
    assign byp_wr    = fire && view == VIEW_BYPASS && req_write && not_empty;
    assign ctl_wr    = fire && view == VIEW_CTRL && req_write;

    assign tail_idx  = head + count[AW-1:0];
    assign last_idx  = tail_idx - AW'(1);

    itc_cell_store #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (push || byp_wr),
        .wr_idx  (push ? tail_idx : last_idx),
        .wr_data (req_wdata),
        .rd_idx  (head),
        .rd_data (head_data)
    );

    itc_cell_tags #(.DEPTH(DEPTH)) u_tags (
        .clk    (clk),
        .rst_n  (rst_n),
        .pop    (pop),
        .push   (push),
        .ctl_wr (ctl_wr),
        .ctl_t  (req_wdata[TAG_T_BIT]),
        .ctl_e  (req_wdata[TAG_E_BIT]),
        .ctl_f  (req_wdata[TAG_F_BIT]),
        .head   (head),
        .count  (count),
        .tag_e  (tag_e),
        .tag_f  (tag_f),
        .tag_t  (tag_t)
    );

    itc_cell_park_fsm u_park (
        .clk      (clk),
        .rst_n    (rst_n),
        .stuck_rd (stuck_rd),
        .stuck_wr (stuck_wr),
        .pop      (pop),
        .push     (push),
        .park_rd  (park_rd),
        .park_wr  (park_wr)
    );

    always_comb begin
        ctl_word = '0;
        ctl_word[TAG_DEPTH_LSB +: 4] = 4'(AW);
        ctl_word[TAG_OCC_LSB +: CW]  = count;
        ctl_word[TAG_MODE_BIT]       = 1'b1;
        ctl_word[TAG_T_BIT]          = tag_t;
        ctl_word[TAG_F_BIT]          = tag_f;
        ctl_word[TAG_E_BIT]          = tag_e;
    end

    always_comb begin
        rsp_rdata = '0;
        if (fire && !req_write) begin
            unique case (view)
                VIEW_BYPASS: rsp_rdata = head_data;
                VIEW_CTRL:   rsp_rdata = ctl_word;
                default:     rsp_rdata = not_empty ? head_data : '0;
            endcase
        end
    end

    // R11
    ready_only_blocking_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |-> view == VIEW_EF_BLOCK);

    // R11
    no_ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> !req_ready);

    // R9
    byp_keeps_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        byp_wr |=> $stable(count) && $stable(head));

endmodule

// File: tb/sim_itc_fifo_cell.sv
module sim_itc_fifo_cell;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_view = 2'd0;
    logic        req_write = 1'b0;
    logic [63:0] req_wdata = '0;
    logic        req_ready;
    logic [63:0] rsp_rdata;
    logic        park_rd, park_wr;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // behavioural reference state
    logic [63:0] mm [8];
    int mh = 0, mc = 0, mst = 0;
    bit me = 1, mf = 0, mt = 0;

    always #2.5 clk = ~clk;

    itc_fifo_cell u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_view(req_view),
        .req_write(req_write), .req_wdata(req_wdata), .req_ready(req_ready),
        .rsp_rdata(rsp_rdata), .park_rd(park_rd), .park_wr(park_wr)
    );

    function automatic logic [63:0] model_ctl();
        logic [63:0] w = '0;
        w[31:28] = 4'd3;
        w[21:18] = 4'(mc);
        w[17] = 1'b1;
        w[16] = mt;
        w[1] = mf;
        w[0] = me;
        return w;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic acc(input logic [1:0] v, input logic w, input logic [63:0] d,
                       input string req);
        bit stk_rd, stk_wr, rdy, pushed, popped;
        logic [63:0] erd;
        @(negedge clk);
        req_valid = 1'b1; req_view = v; req_write = w; req_wdata = d;
        #1;
        stk_rd = (v == 2) && !w && me;
        stk_wr = (v == 2) && w && mf;
        rdy = !(stk_rd || stk_wr);
        erd = '0;
        if (rdy && !w) begin
            if (v == 0) erd = mm[mh];
            else if (v == 1) erd = model_ctl();
            else erd = (mc > 0) ? mm[mh] : '0;
        end
        check(req_ready == rdy, req, "ready", 64'(req_ready), 64'(rdy));
        check(rsp_rdata == erd, req, "rdata", rsp_rdata, erd);
        check({park_rd, park_wr} == {mst == 1, mst == 2}, req, "park",
              64'({park_rd, park_wr}), 64'({mst == 1, mst == 2}));
        pushed = 0; popped = 0;
        if (rdy) begin
            if (v >= 2 && !w && mc > 0) begin
                mh = (mh + 1) % 8; mc--; mf = 0; me = (mc == 0); popped = 1;
            end else if (v >= 2 && w && mc < 8) begin
                mm[(mh + mc) % 8] = d; mc++; me = 0; mf = (mc == 8); pushed = 1;
            end else if (v == 0 && w && mc > 0) begin
                mm[(mh + mc - 1) % 8] = d;
            end else if (v == 1 && w) begin
                mt = d[16]; me = d[0]; mf = d[1];
                if (d[0]) mc = 0;
            end
        end
        if (mst == 0) begin
            if (stk_rd) mst = 1;
            else if (stk_wr) mst = 2;
        end else if (mst == 1 && pushed) mst = 0;
        else if (mst == 2 && popped) mst = 0;
    endtask

    initial begin
        for (int i = 0; i < 8; i++) mm[i] = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        acc(2'd1, 0, 0, "R1");
        acc(2'd0, 0, 0, "R1");
        check(rsp_rdata == 64'h0, "R1", "bypass after reset", rsp_rdata, 64'h0);
        acc(2'd3, 0, 0, "R7");
        acc(2'd1, 0, 0, "R7");

        acc(2'd2, 0, 0, "R5");
        acc(2'd2, 0, 0, "R5");
        acc(2'd2, 1, 64'hA1, "R5");
        acc(2'd2, 0, 0, "R5");

        for (int i = 0; i < 8; i++) acc(2'd3, 1, 64'h100 + 64'(i), "R3");
        acc(2'd1, 0, 0, "R3");
        acc(2'd3, 1, 64'hDEAD, "R7");
        acc(2'd1, 0, 0, "R7");

        acc(2'd2, 1, 64'hBEEF, "R6");
        acc(2'd2, 1, 64'hBEEF, "R6");
        acc(2'd0, 0, 0, "R8");
        acc(2'd1, 0, 0, "R8");
        acc(2'd3, 0, 0, "R6");
        acc(2'd2, 1, 64'hBEEF, "R6");

        acc(2'd0, 1, 64'h5555, "R9");
        for (int i = 0; i < 8; i++) acc(2'd2, 0, 0, "R4");
        acc(2'd1, 0, 0, "R4");
        acc(2'd0, 1, 64'h7777, "R9");
        acc(2'd1, 0, 0, "R9");
        acc(2'd3, 1, 64'h11, "R9");
        acc(2'd0, 0, 0, "R9");

        acc(2'd1, 1, 64'h1_0000, "R10");
        acc(2'd1, 0, 0, "R10");
        acc(2'd1, 1, 64'hFFFF_0001, "R10");
        acc(2'd1, 0, 0, "R2");
        acc(2'd3, 0, 0, "R10");
        acc(2'd1, 1, 64'h2, "R10");
        acc(2'd2, 1, 64'h9, "R6");
        acc(2'd1, 0, 0, "R2");
        acc(2'd3, 1, 64'h9, "R11");
        acc(2'd2, 0, 0, "R6");
        acc(2'd1, 0, 0, "R6");

        @(negedge clk);
        req_valid = 1'b0;
        #1;
        check(req_ready == 1'b0, "R11", "ready while idle", 64'(req_ready), 64'h0);
        check(rsp_rdata == '0, "R11", "rdata while idle", rsp_rdata, 64'h0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule